// File: doc/BRIEF.md
# Banked Register File with Stack

This block holds the 128-byte internal data store of a small 8-bit controller core. Instruction logic reaches it in four ways:
- by register number R0 to R7, relocated into one of four 8-byte banks by two bits of the status byte;
- by a flat 7-bit direct address;
- indirectly, through R0 or R1 of the active bank used as a pointer;
- through an upward-growing stack addressed by an 8-bit stack pointer.

Single bits in the bit-addressable area at 20H to 2FH can be set or cleared.

All reads are combinational views of the current contents. One write-type operation, chosen by `op_i`, takes effect at each rising clock edge. The stack pointer resets to 07H, so the first push lands at 08H, which is the first byte of bank 1. Firmware must move the pointer up before it uses bank 1.

Top module: `bankreg_file`

## Requirements
- R1: While `rst_n` is low and after it is released, every byte of the store reads 00H, `sp_o` reads 07H and `pop_data_o` reads 00H.
- R2: Register number n with status bits 4 (RS1) and 3 (RS0) equal to b maps to store address 8*b+n. This holds for `reg_rdata_o` and for op REG_WR (op code 1), which writes `wdata_i` there.
- R3: Direct address a (00H to 7FH) is read on `dir_rdata_o` and written by op DIR_WR (op code 2). Addresses 00H to 07H always reach bank 0 registers, whatever bank is selected.
- R4: `ind_rdata_o` reads, and op IND_WR (op code 3) writes, the byte addressed by bits 6:0 of R0 (`ptr_sel_i`=0) or R1 (`ptr_sel_i`=1) of the active bank. Pointer bit 7 is ignored.
- R5: Op PUSH (op code 4) first increments `sp_o` and then writes `wdata_i` at the new pointer's bits 6:0. The first push after reset writes 08H.
- R6: Op POP (op code 5) loads `pop_data_o` with the byte at `sp_o` bits 6:0 and decrements `sp_o`, both in the same edge.
- R7: Op SP_LOAD (op code 6) loads `sp_o` from `wdata_i`. Any op other than PUSH, POP and SP_LOAD leaves `sp_o` unchanged.
- R8: Op BIT (op code 7) takes bit address `wdata_i[6:0]` and value `wdata_i[7]`. It writes that value into bit `wdata_i[2:0]` of byte 20H+`wdata_i[6:3]` and leaves the other seven bits of the byte unchanged.
- R9: Status bits other than 4 and 3 have no effect on bank mapping. Op NOP (op code 0) changes no byte and leaves `sp_o` unchanged.
- R10: The stack pointer wraps modulo 256: a push from FFH gives 00H and writes byte 00H; a pop from 00H gives FFH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_i | input | 3 | Operation code for this edge |
| status_i | input | 8 | Status byte; bits 4:3 select the bank |
| reg_num_i | input | 3 | Register number R0..R7 |
| dir_addr_i | input | 7 | Direct address |
| ptr_sel_i | input | 1 | Pointer register for indirect access: 0=R0, 1=R1 |
| wdata_i | input | 8 | Write, push, pointer-load or bit-op data |
| reg_rdata_o | output | 8 | Byte at the mapped register |
| dir_rdata_o | output | 8 | Byte at the direct address |
| ind_rdata_o | output | 8 | Byte addressed by the selected pointer |
| sp_o | output | 8 | Stack pointer |
| pop_data_o | output | 8 | Byte read by the last pop |

## Verification
The same register numbers are written under each of the four bank codes. A status byte is used whose unrelated bits are all set, so that a mistake in bank decoding or in bit selection lands in the wrong window. Direct writes to 00H to 07H under a non-zero bank show that low direct addresses bypass the bank map. A pointer with bit 7 set shows that the indirect path uses only seven bits. Pushes and pops are run in sequence, with their data checked at fixed addresses, to separate increment-before-write from write-before-increment. A pointer load to FFH and to 00H shows the wrap in both directions. Set and clear at the two ends of the bit region show that neighbouring bits keep their values.

// File: rtl/bankreg_pkg.sv
`timescale 1ns/1ps
package bankreg_pkg;
    localparam int DW        = 8;
    localparam int DEPTH     = 128;
    localparam int AW        = $clog2(DEPTH);
    localparam int NREG      = 8;
    localparam int RW        = $clog2(NREG);
    localparam int NBANK     = 4;
    localparam int BW        = $clog2(NBANK);
    localparam int BANK_LSB  = 3;
    localparam int SPW       = 8;
    localparam logic [SPW-1:0] SP_RESET = 8'h07;
    localparam logic [AW-1:0]  BIT_BASE = 7'h20;

    typedef enum logic [2:0] {
        OP_NOP    = 3'd0,
        OP_REG_WR = 3'd1,
        OP_DIR_WR = 3'd2,
        OP_IND_WR = 3'd3,
        OP_PUSH   = 3'd4,
        OP_POP    = 3'd5,
        OP_SP_LD  = 3'd6,
        OP_BIT    = 3'd7
    } op_e;

    typedef struct packed {
        logic [SPW-1:0] sp;
        logic [DW-1:0]  pop_data;
    } state_t;
endpackage

// File: rtl/bankreg_map.sv
`timescale 1ns/1ps
module bankreg_map
    import bankreg_pkg::*;
(
    input  logic [BW-1:0] bank_i,
    input  logic [RW-1:0] rnum_i,
    output logic [AW-1:0] addr_o
);
    localparam int PAD = AW - BW - RW;
    assign addr_o = {{PAD{1'b0}}, bank_i, rnum_i};
endmodule

// File: rtl/bankreg_rdport.sv
`timescale 1ns/1ps
module bankreg_rdport
    import bankreg_pkg::*;
(
    input  logic [DEPTH-1:0][DW-1:0] mem_i,
    input  logic [AW-1:0]            addr_i,
    output logic [DW-1:0]            data_o
);
    assign data_o = mem_i[addr_i];
endmodule

// File: rtl/bankreg_ram.sv
`timescale 1ns/1ps
module bankreg_ram
    import bankreg_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we_i,
    input  logic [AW-1:0]            waddr_i,
    input  logic [DW-1:0]            wdata_i,
    input  logic [DW-1:0]            wmask_i,
    output logic [DEPTH-1:0][DW-1:0] mem_o
);
    logic [DEPTH-1:0][DW-1:0] mem_d, mem_q;

    always_comb begin
        mem_d = mem_q;
        if (we_i) begin
            mem_d[waddr_i] = (mem_q[waddr_i] & ~wmask_i) | (wdata_i & wmask_i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mem_q <= '0;
        else        mem_q <= mem_d;
    end

    assign mem_o = mem_q;

    // full-byte write lands intact (R3, R2, R4, R5)
    assert_byte_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && wmask_i == '1) |=> mem_q[$past(waddr_i)] == $past(wdata_i));

    // masked write keeps unmasked bits (R8)
    assert_mask_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> ((mem_q[$past(waddr_i)] & ~$past(wmask_i)) ==
                  ($past(mem_q[waddr_i]) & ~$past(wmask_i))));
endmodule

// File: rtl/bankreg_file.sv
`timescale 1ns/1ps
module bankreg_file
    import bankreg_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic [2:0]    op_i,
    input  logic [7:0]    status_i,
    input  logic [2:0]    reg_num_i,
    input  logic [6:0]    dir_addr_i,
    input  logic          ptr_sel_i,
    input  logic [7:0]    wdata_i,
    output logic [7:0]    reg_rdata_o,
    output logic [7:0]    dir_rdata_o,
    output logic [7:0]    ind_rdata_o,
    output logic [7:0]    sp_o,
    output logic [7:0]    pop_data_o
);
    localparam int NPORT = 5;
    localparam int P_REG = 0, P_DIR = 1, P_PTR = 2, P_IND = 3, P_TOP = 4;
    localparam int BITSEL = $clog2(DW);

    op_e                      op;
    logic [BW-1:0]            bank;
    logic [DEPTH-1:0][DW-1:0] mem;
    logic [AW-1:0]            reg_addr, ptr_addr;
    logic [AW-1:0]            rd_addr [NPORT];
    logic [DW-1:0]            rd_data [NPORT];
    logic                     we;
    logic [AW-1:0]            waddr;
    logic [DW-1:0]            wdata, wmask;
    logic [SPW-1:0]           sp_inc, sp_dec;
    state_t                   st_d, st_q;

    assign op   = op_e'(op_i);
    assign bank = status_i[BANK_LSB +: BW];

    bankreg_map u_map_reg (.bank_i(bank), .rnum_i(reg_num_i), .addr_o(reg_addr));
    bankreg_map u_map_ptr (.bank_i(bank), .rnum_i({{(RW-1){1'b0}}, ptr_sel_i}),
                           .addr_o(ptr_addr));

    assign rd_addr[P_REG] = reg_addr;
    assign rd_addr[P_DIR] = dir_addr_i;
    assign rd_addr[P_PTR] = ptr_addr;
    assign rd_addr[P_IND] = rd_data[P_PTR][AW-1:0];
    assign rd_addr[P_TOP] = st_q.sp[AW-1:0];

    for (genvar g = 0; g < NPORT; g++) begin : g_rd
        bankreg_rdport u_rd (.mem_i(mem), .addr_i(rd_addr[g]), .data_o(rd_data[g]));
    end

    bankreg_ram u_ram (
        .clk(clk), .rst_n(rst_n), .we_i(we), .waddr_i(waddr),
        .wdata_i(wdata), .wmask_i(wmask), .mem_o(mem)
    );

    assign sp_inc = st_q.sp + 1'b1;
    assign sp_dec = st_q.sp - 1'b1;

    always_comb begin
        st_d  = st_q;
        we    = 1'b0;
        waddr = dir_addr_i;
        wdata = wdata_i;
        wmask = '1;
        case (op)
            OP_REG_WR: begin we = 1'b1; waddr = reg_addr; end
            OP_DIR_WR: begin we = 1'b1; waddr = dir_addr_i; end
            OP_IND_WR: begin we = 1'b1; waddr = rd_data[P_PTR][AW-1:0]; end
            OP_PUSH: begin
                we        = 1'b1;
                waddr     = sp_inc[AW-1:0];
                st_d.sp   = sp_inc;
            end
            OP_POP: begin
                st_d.pop_data = rd_data[P_TOP];
                st_d.sp       = sp_dec;
            end
            OP_SP_LD: st_d.sp = wdata_i;
            OP_BIT: begin
                we    = 1'b1;
                waddr = BIT_BASE + AW'(wdata_i[AW-1:BITSEL]);
                wdata = {DW{wdata_i[DW-1]}};
                wmask = DW'(1) << wdata_i[BITSEL-1:0];
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{sp: SP_RESET, pop_data: '0};
        else        st_q <= st_d;
    end

    assign reg_rdata_o = rd_data[P_REG];
    assign dir_rdata_o = rd_data[P_DIR];
    assign ind_rdata_o = rd_data[P_IND];
    assign sp_o        = st_q.sp;
    assign pop_data_o  = st_q.pop_data;

    assert_push_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_PUSH) |=> sp_o == $past(sp_o) + 8'd1);
    assert_push_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_PUSH) |=> mem[sp_o[AW-1:0]] == $past(wdata_i));
    assert_pop_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_POP) |=> sp_o == $past(sp_o) - 8'd1);
    assert_pop_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_POP) |=> pop_data_o == $past(mem[sp_o[AW-1:0]]));
    assert_sp_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_SP_LD) |=> sp_o == $past(wdata_i));
    assert_sp_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i != OP_PUSH && op_i != OP_POP && op_i != OP_SP_LD) |=> $stable(sp_o));
    assert_nop_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_NOP) |=> $stable(mem));
endmodule

// File: tb/bankreg_file_test.sv
`timescale 1ns/1ps
module bankreg_file_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] op_i = '0;
    logic [7:0] status_i = '0;
    logic [2:0] reg_num_i = '0;
    logic [6:0] dir_addr_i = '0;
    logic       ptr_sel_i = 1'b0;
    logic [7:0] wdata_i = '0;
    logic [7:0] reg_rdata_o, dir_rdata_o, ind_rdata_o, sp_o, pop_data_o;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    bankreg_file uut (.*);

    typedef struct packed {
        logic [2:0] op;
        logic [7:0] st;
        logic [2:0] rn;
        logic [6:0] da;
        logic       ps;
        logic [7:0] wd;
        logic [6:0] ca;
        logic [7:0] cv;
        logic [7:0] sp;
    } row_t;

    localparam int NROW = 17;
    localparam row_t TBL [NROW] = '{
        '{3'd1, 8'h00, 3'd3, 7'h00, 1'b0, 8'h11, 7'h03, 8'h11, 8'h07}, // R2 bank0
        '{3'd1, 8'h08, 3'd3, 7'h00, 1'b0, 8'h22, 7'h0B, 8'h22, 8'h07}, // R2 bank1
        '{3'd1, 8'h10, 3'd7, 7'h00, 1'b0, 8'h33, 7'h17, 8'h33, 8'h07}, // R2 bank2
        '{3'd1, 8'h18, 3'd0, 7'h00, 1'b0, 8'h44, 7'h18, 8'h44, 8'h07}, // R2 bank3
        '{3'd1, 8'hE7, 3'd5, 7'h00, 1'b0, 8'h55, 7'h05, 8'h55, 8'h07}, // R9 other bits
        '{3'd2, 8'h00, 3'd0, 7'h7F, 1'b0, 8'h66, 7'h7F, 8'h66, 8'h07}, // R3 top
        '{3'd2, 8'h18, 3'd0, 7'h04, 1'b0, 8'h77, 7'h04, 8'h77, 8'h07}, // R3 low
        '{3'd1, 8'h10, 3'd0, 7'h00, 1'b0, 8'hC0, 7'h10, 8'hC0, 8'h07}, // R4 ptr R0
        '{3'd3, 8'h10, 3'd0, 7'h00, 1'b0, 8'h99, 7'h40, 8'h99, 8'h07}, // R4 bit7 ignored
        '{3'd1, 8'h10, 3'd1, 7'h00, 1'b0, 8'h30, 7'h11, 8'h30, 8'h07}, // R4 ptr R1
        '{3'd3, 8'h10, 3'd0, 7'h00, 1'b1, 8'hAB, 7'h30, 8'hAB, 8'h07}, // R4 via R1
        '{3'd4, 8'h00, 3'd0, 7'h00, 1'b0, 8'h5A, 7'h08, 8'h5A, 8'h08}, // R5 first push
        '{3'd4, 8'h00, 3'd0, 7'h00, 1'b0, 8'hA5, 7'h09, 8'hA5, 8'h09}, // R5 second
        '{3'd7, 8'h00, 3'd0, 7'h00, 1'b0, 8'h8B, 7'h21, 8'h08, 8'h09}, // R8 set
        '{3'd7, 8'h00, 3'd0, 7'h00, 1'b0, 8'h8F, 7'h21, 8'h88, 8'h09}, // R8 set other
        '{3'd7, 8'h00, 3'd0, 7'h00, 1'b0, 8'h0B, 7'h21, 8'h80, 8'h09}, // R8 clear
        '{3'd7, 8'h00, 3'd0, 7'h00, 1'b0, 8'hFF, 7'h2F, 8'h80, 8'h09}  // R8 last bit
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic do_op(input logic [2:0] op, input logic [7:0] wd);
        @(negedge clk);
        op_i = op;
        wdata_i = wd;
        @(posedge clk);
        #1 op_i = 3'd0;
    endtask

    initial begin
        #100000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R1 during reset
        #12;
        check("R1 sp in reset", sp_o, 8'h07);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 sp", sp_o, 8'h07);
        check("R1 pop_data", pop_data_o, 8'h00);
        for (int a = 0; a < 128; a += 9) begin
            dir_addr_i = 7'(a);
            #1 check("R1 ram clear", dir_rdata_o, 8'h00);
        end

        for (int i = 0; i < NROW; i++) begin
            @(negedge clk);
            op_i = TBL[i].op; status_i = TBL[i].st; reg_num_i = TBL[i].rn;
            dir_addr_i = TBL[i].da; ptr_sel_i = TBL[i].ps; wdata_i = TBL[i].wd;
            @(posedge clk);
            #1 op_i = 3'd0; dir_addr_i = TBL[i].ca;
            #1 check($sformatf("row %0d data", i), dir_rdata_o, TBL[i].cv);
            check($sformatf("row %0d sp", i), sp_o, TBL[i].sp);
        end

        // R2 read path
        @(negedge clk);
        status_i = 8'h08; reg_num_i = 3'd3;
        #1 check("R2 reg read bank1", reg_rdata_o, 8'h22);
        status_i = 8'hE7; reg_num_i = 3'd5;
        #1 check("R9 reg read masked status", reg_rdata_o, 8'h55);
        // R4 read path
        status_i = 8'h10; ptr_sel_i = 1'b0;
        #1 check("R4 ind read via R0", ind_rdata_o, 8'h99);
        ptr_sel_i = 1'b1;
        #1 check("R4 ind read via R1", ind_rdata_o, 8'hAB);

        // R9 NOP with data present
        dir_addr_i = 7'h08;
        do_op(3'd0, 8'hEE);
        #1 check("R9 nop sp", sp_o, 8'h09);
        check("R9 nop data", dir_rdata_o, 8'h5A);

        // R6 pops
        do_op(3'd5, 8'h00);
        #1 check("R6 pop1 data", pop_data_o, 8'hA5);
        check("R6 pop1 sp", sp_o, 8'h08);
        do_op(3'd5, 8'h00);
        #1 check("R6 pop2 data", pop_data_o, 8'h5A);
        check("R6 pop2 sp", sp_o, 8'h07);

        // R7 load, R10 wrap
        do_op(3'd6, 8'hFF);
        #1 check("R7 sp load", sp_o, 8'hFF);
        do_op(3'd4, 8'h3C);
        #1 check("R10 push wrap sp", sp_o, 8'h00);
        dir_addr_i = 7'h00;
        #1 check("R10 push wrap data", dir_rdata_o, 8'h3C);
        do_op(3'd5, 8'h00);
        #1 check("R10 pop wrap sp", sp_o, 8'hFF);
        check("R10 pop wrap data", pop_data_o, 8'h3C);
        do_op(3'd2, 8'h12);
        #1 check("R7 sp hold on write", sp_o, 8'hFF);

        // R1 reset again
        @(negedge clk);
        rst_n = 1'b0;
        #1 dir_addr_i = 7'h7F;
        #1 check("R1 reset clears ram", dir_rdata_o, 8'h00);
        check("R1 reset sp", sp_o, 8'h07);
        check("R1 reset pop_data", pop_data_o, 8'h00);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule